// File: doc/BRIEF.md
# Four-Port SDRAM Bank-Lookahead Command Scheduler

This block sits between four requesting masters and one SDRAM device. Each master presents one access at a time (bank, row, column, read or write) with a valid/ready handshake, and all four requests are visible to the scheduler in the same cycle. The scheduler drives one SDRAM command per clock. For every bank it keeps the open row and the precharge and activate timers. From these it decides each cycle whether a column access, a burst stop, an activate, a precharge or a no-operation goes to the device.

Row-switch cost is hidden by working ahead. While a burst runs in one bank, the scheduler may precharge and activate rows in other banks that waiting masters need. When consecutive reads find their rows already open, the next READ is issued exactly as the previous burst's command window closes. Its data then follows the previous data with no bubble. Column accesses that hit an open row take precedence. Among equals, the masters are served in rotating order. A master's request is accepted, with ready high, in the same cycle its READ or WRITE is driven, and an accepted access is never withdrawn.

The CAS latency (2 or 3) is chosen by a configuration input. tRP, tRCD and the burst length are parameters (defaults 2, 2, 2).

Top module: `sdsched_top`

## Requirements
- R1: During and right after reset, `cmd` is NOP, `req_rdy` is zero and `rdata_beat` is low. Every bank's row is treated as unknown, so the first access to any bank after reset starts with PRECHARGE.
- R2: Exactly one command is driven per cycle, encoded NOP=0, PRECHARGE=1, ACTIVE=2, READ=3, WRITE=4, BURST STOP=5. A cycle with no legal command drives NOP.
- R3: An ACTIVE to a bank comes at least T_RP cycles after that bank's PRECHARGE, and never while the bank is open. With default parameters, an isolated access to a bank needing a row change is accepted 4 cycles after it appears, with the sequence PRECHARGE, NOP, ACTIVE, NOP, column command.
- R4: A READ or WRITE goes to a bank that is open on the requesting master's row, at least T_RCD cycles after its ACTIVE. `cmd_addr` carries the row for ACTIVE and the column for READ/WRITE.
- R5: `req_rdy` has at most one bit set. It is set only for the master whose READ or WRITE is driven in that cycle, and `cmd_bank`/`cmd_addr` then match that master's bank and column. An isolated hit on an open row is accepted in the cycle it appears.
- R6: A request hitting an open row whose timing allows it is served before any ACTIVE or PRECHARGE. No PRECHARGE goes to a bank while a valid request hits its open row.
- R7: PRECHARGE and ACTIVE for other banks are issued while read data of an earlier access is still returning.
- R8: `rdata_beat` is high for BURST cycles starting CL cycles after each READ, where CL is 3 when `cas3` is 1 and 2 otherwise. Reads to open rows from four masters produce one unbroken run of 4×BURST beats, with READs spaced exactly BURST cycles apart.
- R9: Exactly BURST cycles after a READ or WRITE, the scheduler drives either the next column command or BURST STOP.
- R10: A WRITE following a READ waits until the read data has left the bus, i.e. CL+BURST cycles after the READ. A READ may follow a WRITE BURST cycles later.
- R11: When several masters' column accesses are ready together, they are granted in rotating order: each grant goes to the next master after the previously granted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas3 | input | 1 | CAS latency select: 1 gives 3 cycles, 0 gives 2 |
| req_vld | input | NPORT | Request valid, one bit per master |
| req_bank | input | NPORT*BA_W | Target bank per master, master p at bits [p*BA_W +: BA_W] |
| req_row | input | NPORT*ROW_W | Target row per master |
| req_col | input | NPORT*COL_W | Target column per master |
| req_wr | input | NPORT | 1 = write, 0 = read, per master |
| req_rdy | output | NPORT | Request accepted this cycle |
| cmd | output | 3 | SDRAM command code |
| cmd_bank | output | BA_W | Bank of the command |
| cmd_addr | output | AW | Row (ACTIVE) or column (READ/WRITE), else zero |
| gnt_vld | output | 1 | A request is granted this cycle |
| gnt_port | output | PW | Index of the granted master |
| rdata_beat | output | 1 | Read data expected on the device bus this cycle |

## Verification
Single isolated accesses check the row-change path against the open-row path under both CAS latencies. They separate a missing precharge from a timer off by one cycle. Four masters that all need row changes show whether precharge and activate overlap returning read data. Four masters that all hit open rows show whether reads chain without bubbles and follow the rotating order. Mixed hit/miss pairs and read/write pairs show the hit preference, protection of a bank with a pending hit, and bus turnaround spacing. A reset in mid-run checks that the stored rows are forgotten.

// File: rtl/sdsched_pkg.sv
package sdsched_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_PRE = 3'd1,
        CMD_ACT = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_BST = 3'd5
    } cmd_e;

endpackage

// File: rtl/sdsched_bank.sv
module sdsched_bank #(
    parameter int ROW_W = 13,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_pre,
    input  logic             do_act,
    input  logic             do_col,
    input  logic [ROW_W-1:0] act_row,
    output logic             is_open,
    output logic             row_known,
    output logic [ROW_W-1:0] open_row,
    output logic             rp_done,
    output logic             rcd_done
);

    localparam int RPW  = $clog2(T_RP + 1);
    localparam int RCDW = $clog2(T_RCD + 1);

    typedef struct packed {
        logic             open;
        logic             known;
        logic [ROW_W-1:0] row;
        logic [RPW-1:0]   rp_cnt;
        logic [RCDW-1:0]  rcd_cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.rp_cnt != '0)
            st_d.rp_cnt = st_q.rp_cnt - 1'b1;
        if (st_q.rcd_cnt != '0)
            st_d.rcd_cnt = st_q.rcd_cnt - 1'b1;
        if (do_pre) begin
            st_d.open   = 1'b0;
            st_d.known  = 1'b0;
            st_d.rp_cnt = RPW'(T_RP - 1);
        end else if (do_act) begin
            st_d.open    = 1'b1;
            st_d.known   = 1'b1;
            st_d.row     = act_row;
            st_d.rcd_cnt = RCDW'(T_RCD - 1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.open    <= 1'b1;
            st_q.known   <= 1'b0;
            st_q.row     <= '0;
            st_q.rp_cnt  <= '0;
            st_q.rcd_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign is_open   = st_q.open;
    assign row_known = st_q.known;
    assign open_row  = st_q.row;
    assign rp_done   = (st_q.rp_cnt == '0);
    assign rcd_done  = (st_q.rcd_cnt == '0);

    AST_ACT_AFTER_RP: assert property (@(posedge clk) disable iff (!rst_n) do_act |-> (!st_q.open && st_q.rp_cnt == '0)); // R3
    AST_COL_AFTER_RCD: assert property (@(posedge clk) disable iff (!rst_n) do_col |-> (st_q.open && st_q.known && st_q.rcd_cnt == '0)); // R4
    AST_ONE_BANK_OP: assert property (@(posedge clk) disable iff (!rst_n) $countones({do_pre, do_act, do_col}) <= 1); // R2

endmodule

// File: rtl/sdsched_rdbeat.sv
module sdsched_rdbeat #(
    parameter int BURST = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cas3,
    input  logic rd_issue,
    output logic beat
);

    localparam int CW = $clog2(BURST + 1);

    typedef struct packed {
        logic [1:0]    pipe;
        logic [CW-1:0] cnt;
    } beat_st_t;

    beat_st_t st_d, st_q;
    logic     arrive;

    always_comb begin
        st_d      = st_q;
        arrive    = cas3 ? st_q.pipe[1] : st_q.pipe[0];
        st_d.pipe = {st_q.pipe[0], rd_issue};
        if (arrive)
            st_d.cnt = CW'(BURST);
        else if (st_q.cnt != '0)
            st_d.cnt = st_q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign beat = (st_q.cnt != '0);

    AST_BEAT_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n) $rose(beat) |-> $past(st_q.pipe != 2'b00)); // R8

endmodule

// File: rtl/sdsched_top.sv
module sdsched_top
    import sdsched_pkg::*;
#(
    parameter int NPORT = 4,
    parameter int NBANK = 4,
    parameter int ROW_W = 13,
    parameter int COL_W = 10,
    parameter int T_RP  = 2,
    parameter int T_RCD = 2,
    parameter int BURST = 2,
    localparam int PW   = $clog2(NPORT),
    localparam int BA_W = $clog2(NBANK),
    localparam int AW   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cas3,
    input  logic [NPORT-1:0]       req_vld,
    input  logic [NPORT*BA_W-1:0]  req_bank,
    input  logic [NPORT*ROW_W-1:0] req_row,
    input  logic [NPORT*COL_W-1:0] req_col,
    input  logic [NPORT-1:0]       req_wr,
    output logic [NPORT-1:0]       req_rdy,
    output cmd_e                   cmd,
    output logic [BA_W-1:0]        cmd_bank,
    output logic [AW-1:0]          cmd_addr,
    output logic                   gnt_vld,
    output logic [PW-1:0]          gnt_port,
    output logic                   rdata_beat
);

    localparam int CLW = $clog2(BURST + 1);
    localparam int BW  = $clog2(BURST + 4);

    typedef struct packed {
        logic [PW-1:0]   rr;
        logic [CLW-1:0]  col_left;
        logic [BW-1:0]   bus;
        logic [BA_W-1:0] last_bank;
    } sch_st_t;

    sch_st_t st_d, st_q;

    logic [NBANK-1:0] is_open, row_known, rp_done, rcd_done;
    logic [NBANK-1:0] do_pre, do_act, do_col, bank_hit;
    logic [ROW_W-1:0] open_row [NBANK];
    logic [ROW_W-1:0] act_row;
    logic [BA_W-1:0]  pb   [NPORT];
    logic [ROW_W-1:0] prow [NPORT];
    logic [COL_W-1:0] pcol [NPORT];
    logic [NPORT-1:0] hit;
    logic             rd_issue;

    // per-bank row and timer state
    for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
        sdsched_bank #(.ROW_W(ROW_W), .T_RP(T_RP), .T_RCD(T_RCD)) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .do_pre   (do_pre[gb]),
            .do_act   (do_act[gb]),
            .do_col   (do_col[gb]),
            .act_row  (act_row),
            .is_open  (is_open[gb]),
            .row_known(row_known[gb]),
            .open_row (open_row[gb]),
            .rp_done  (rp_done[gb]),
            .rcd_done (rcd_done[gb])
        );
    end

    sdsched_rdbeat #(.BURST(BURST)) i_rdbeat (
        .clk     (clk),
        .rst_n   (rst_n),
        .cas3    (cas3),
        .rd_issue(rd_issue),
        .beat    (rdata_beat)
    );

    // request decode and row-hit detection
    always_comb begin
        bank_hit = '0;
        for (int p = 0; p < NPORT; p++) begin
            pb[p]   = req_bank[p*BA_W +: BA_W];
            prow[p] = req_row[p*ROW_W +: ROW_W];
            pcol[p] = req_col[p*COL_W +: COL_W];
            hit[p]  = req_vld[p] && is_open[pb[p]] && row_known[pb[p]]
                      && (open_row[pb[p]] == prow[p]);
            if (hit[p])
                bank_hit[pb[p]] = 1'b1;
        end
    end

    // command selection
    always_comb begin
        logic [PW-1:0]   idx, col_p, act_p, pre_p;
        logic [BA_W-1:0] b;
        logic            col_found, act_found, pre_found, bank_busy;
        logic [BW-1:0]   cl_v;

        st_d     = st_q;
        cmd      = CMD_NOP;
        cmd_bank = '0;
        cmd_addr = '0;
        req_rdy  = '0;
        gnt_vld  = 1'b0;
        gnt_port = '0;
        do_pre   = '0;
        do_act   = '0;
        do_col   = '0;
        act_row  = '0;
        rd_issue = 1'b0;
        col_found = 1'b0; act_found = 1'b0; pre_found = 1'b0;
        col_p = '0; act_p = '0; pre_p = '0;
        cl_v  = cas3 ? BW'(3) : BW'(2);

        if (st_q.col_left != '0) st_d.col_left = st_q.col_left - 1'b1;
        if (st_q.bus != '0)      st_d.bus      = st_q.bus - 1'b1;

        for (int k = 0; k < NPORT; k++) begin
            idx = PW'((int'(st_q.rr) + k) % NPORT);
            b   = pb[idx];
            bank_busy = (b == st_q.last_bank) && (st_q.col_left != '0 || st_q.bus != '0);
            if (!col_found && hit[idx] && rcd_done[b] && st_q.col_left <= CLW'(1)
                && (!req_wr[idx] || st_q.bus == '0)) begin
                col_found = 1'b1;
                col_p     = idx;
            end
            if (!act_found && req_vld[idx] && !is_open[b] && rp_done[b]) begin
                act_found = 1'b1;
                act_p     = idx;
            end
            if (!pre_found && req_vld[idx] && is_open[b] && !bank_hit[b] && !bank_busy) begin
                pre_found = 1'b1;
                pre_p     = idx;
            end
        end

        if (col_found) begin
            cmd              = req_wr[col_p] ? CMD_WR : CMD_RD;
            cmd_bank         = pb[col_p];
            cmd_addr         = AW'(pcol[col_p]);
            req_rdy[col_p]   = 1'b1;
            gnt_vld          = 1'b1;
            gnt_port         = col_p;
            do_col[pb[col_p]] = 1'b1;
            rd_issue         = !req_wr[col_p];
            st_d.col_left    = CLW'(BURST);
            st_d.bus         = req_wr[col_p] ? BW'(BURST - 1) : BW'(BURST - 1) + cl_v;
            st_d.last_bank   = pb[col_p];
            st_d.rr          = col_p + PW'(1);
        end else if (st_q.col_left == CLW'(1)) begin
            cmd      = CMD_BST;
            cmd_bank = st_q.last_bank;
        end else if (act_found) begin
            cmd               = CMD_ACT;
            cmd_bank          = pb[act_p];
            cmd_addr          = AW'(prow[act_p]);
            act_row           = prow[act_p];
            do_act[pb[act_p]] = 1'b1;
        end else if (pre_found) begin
            cmd               = CMD_PRE;
            cmd_bank          = pb[pre_p];
            do_pre[pb[pre_p]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_RDY_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(req_rdy)); // R5
    AST_RDY_WITH_COL: assert property (@(posedge clk) disable iff (!rst_n) (|req_rdy) |-> ((cmd == CMD_RD || cmd == CMD_WR) && req_vld[gnt_port] && cmd_bank == pb[gnt_port])); // R5
    AST_PRE_SPARES_HIT: assert property (@(posedge clk) disable iff (!rst_n) (cmd == CMD_PRE) |-> !bank_hit[cmd_bank]); // R6
    AST_COL_ON_OPEN_ROW: assert property (@(posedge clk) disable iff (!rst_n) (cmd == CMD_RD || cmd == CMD_WR) |-> (is_open[cmd_bank] && open_row[cmd_bank] == prow[gnt_port])); // R4

endmodule

// File: tb/test_sdsched_top.sv
module test_sdsched_top;
    import sdsched_pkg::*;

    localparam int NP = 4, BA = 2, RW = 13, CW = 10;
    localparam int TRP = 2, TRCD = 2, BL = 2, AW = 13;

    logic clk = 1'b0, rst_n = 1'b0, cas3 = 1'b0;
    logic [NP-1:0]    vld = '0, wr = '0;
    logic [NP*BA-1:0] bnk = '0;
    logic [NP*RW-1:0] row = '0;
    logic [NP*CW-1:0] col = '0;
    logic [NP-1:0]    rdy;
    cmd_e             cmd;
    logic [BA-1:0]    cmd_bank;
    logic [AW-1:0]    cmd_addr;
    logic             gnt_vld, rdata_beat;
    logic [1:0]       gnt_port;

    sdsched_top i_sdsched_top (
        .clk(clk), .rst_n(rst_n), .cas3(cas3), .req_vld(vld), .req_bank(bnk),
        .req_row(row), .req_col(col), .req_wr(wr), .req_rdy(rdy), .cmd(cmd),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .gnt_vld(gnt_vld),
        .gnt_port(gnt_port), .rdata_beat(rdata_beat)
    );

    always #10 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // independent model of the device-side rules
    int   pre_c [4], act_c [4], mrow [4];
    bit   mopen [4];
    cmd_e hist [64];
    bit   expb [64];
    int   bst_due = -1;
    bit   ovl = 0, beat_prev = 0;
    int   beat_hi = 0, beat_rise = 0;
    int   g_cyc [4], g_bank [4], g_addr [4];
    cmd_e g_cmd [4];
    int   g_order [8];
    int   g_n = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin mopen[i] = 1; pre_c[i] = -1000; act_c[i] = -1000; end
            for (int i = 0; i < 64; i++) expb[i] = 0;
            bst_due = -1;
        end else begin
            int gp;
            cyc++;
            hist[cyc % 64] = cmd;
            if (expb[cyc % 64] || rdata_beat)
                chk(rdata_beat == expb[cyc % 64], "R8 read beat", rdata_beat, expb[cyc % 64]);
            expb[cyc % 64] = 0;
            if (bst_due == cyc)
                chk(cmd == CMD_BST || cmd == CMD_RD || cmd == CMD_WR, "R9 burst end", cmd, CMD_BST);
            if ((cmd == CMD_PRE || cmd == CMD_ACT) && rdata_beat) ovl = 1;
            if (rdata_beat) beat_hi++;
            if (rdata_beat && !beat_prev) beat_rise++;
            beat_prev = rdata_beat;
            case (cmd)
                CMD_PRE: begin mopen[cmd_bank] = 0; pre_c[cmd_bank] = cyc; end
                CMD_ACT: begin
                    chk(!mopen[cmd_bank] && (cyc - pre_c[cmd_bank] >= TRP), "R3 act after pre",
                        cyc - pre_c[cmd_bank], TRP);
                    mopen[cmd_bank] = 1; mrow[cmd_bank] = int'(cmd_addr); act_c[cmd_bank] = cyc;
                end
                CMD_RD, CMD_WR: begin
                    chk(mopen[cmd_bank] && (cyc - act_c[cmd_bank] >= TRCD), "R4 col after act",
                        cyc - act_c[cmd_bank], TRCD);
                    gp = 0;
                    for (int i = 0; i < 4; i++) if (rdy[i]) gp = i;
                    chk($countones(rdy) == 1 && int'(row[gp*RW +: RW]) == mrow[cmd_bank],
                        "R5 grant row", int'(row[gp*RW +: RW]), mrow[cmd_bank]);
                    g_cyc[gp] = cyc; g_cmd[gp] = cmd; g_bank[gp] = int'(cmd_bank);
                    g_addr[gp] = int'(cmd_addr);
                    if (g_n < 8) g_order[g_n] = gp;
                    g_n++;
                    bst_due = cyc + BL;
                    if (cmd == CMD_RD)
                        for (int i = 0; i < BL; i++) expb[(cyc + (cas3 ? 3 : 2) + i) % 64] = 1;
                end
                default: ;
            endcase
        end
    end

    task automatic req(input int p, input int b, input int r, input int c, input bit w, output int lat);
        int st;
        @(posedge clk); #1;
        bnk[p*BA +: BA] = BA'(b); row[p*RW +: RW] = RW'(r);
        col[p*CW +: CW] = CW'(c); wr[p] = w; vld[p] = 1'b1;
        @(negedge clk); #1;
        st = cyc;
        while (!rdy[p]) begin @(negedge clk); #1; end
        lat = cyc - st;
        @(posedge clk); #1;
        vld[p] = 1'b0;
    endtask

    typedef struct packed {
        int p; int b; int r; int c; bit w; bit cl3; int lat;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{0, 1, 5, 8, 1'b0, 1'b0, 4},
        '{1, 1, 5, 9, 1'b0, 1'b0, 0},
        '{2, 1, 7, 1, 1'b0, 1'b0, 4},
        '{3, 2, 7, 2, 1'b1, 1'b0, 4},
        '{0, 2, 7, 3, 1'b0, 1'b1, 0},
        '{1, 2, 9, 0, 1'b1, 1'b0, 4}
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int l0, l1, l2, l3, st, mn, mx;
        cmd_e seq [7];
        repeat (3) @(posedge clk);
        #1;
        chk(cmd == CMD_NOP && rdy == '0 && rdata_beat == 1'b0, "R1 in reset", int'(cmd), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(cmd == CMD_NOP && rdy == '0 && rdata_beat == 1'b0, "R1 R2 idle after reset", int'(cmd), 0);
        end

        // single accesses from the table
        for (int i = 0; i < 6; i++) begin
            cas3 = VEC[i].cl3;
            req(VEC[i].p, VEC[i].b, VEC[i].r, VEC[i].c, VEC[i].w, l0);
            chk(l0 == VEC[i].lat, "R3 R5 accept latency", l0, VEC[i].lat);
            chk(g_cmd[VEC[i].p] == (VEC[i].w ? CMD_WR : CMD_RD), "R5 column kind",
                g_cmd[VEC[i].p], VEC[i].w ? CMD_WR : CMD_RD);
            chk(g_bank[VEC[i].p] == VEC[i].b && g_addr[VEC[i].p] == VEC[i].c, "R4 R5 bank/col",
                g_addr[VEC[i].p], VEC[i].c);
            repeat (8) @(posedge clk);
            if (VEC[i].lat == 4) begin
                seq = '{CMD_PRE, CMD_NOP, CMD_ACT, CMD_NOP, VEC[i].w ? CMD_WR : CMD_RD, CMD_NOP, CMD_BST};
                st = g_cyc[VEC[i].p] - 4;
                for (int j = 0; j < 7; j++)
                    chk(hist[(st + j) % 64] == seq[j], "R3 R9 command order", hist[(st + j) % 64], seq[j]);
            end
        end
        cas3 = 1'b0;

        // four masters, all needing row changes: lookahead overlap
        ovl = 0;
        fork
            req(0, 0, 3, 10, 1'b0, l0);
            req(1, 1, 4, 11, 1'b0, l1);
            req(2, 2, 5, 12, 1'b0, l2);
            req(3, 3, 6, 13, 1'b0, l3);
        join
        repeat (10) @(posedge clk);
        chk(ovl == 1, "R7 precharge/activate during read data", ovl, 1);

        // four masters, all rows open: seamless reads in rotating order
        beat_hi = 0; beat_rise = 0; g_n = 0;
        fork
            req(0, 0, 3, 20, 1'b0, l0);
            req(1, 1, 4, 21, 1'b0, l1);
            req(2, 2, 5, 22, 1'b0, l2);
            req(3, 3, 6, 23, 1'b0, l3);
        join
        repeat (10) @(posedge clk);
        chk(beat_hi == 4 * BL && beat_rise == 1, "R8 unbroken read run", beat_hi, 4 * BL);
        mn = g_cyc[0]; mx = g_cyc[0];
        for (int i = 1; i < 4; i++) begin
            if (g_cyc[i] < mn) mn = g_cyc[i];
            if (g_cyc[i] > mx) mx = g_cyc[i];
        end
        chk(mx - mn == 3 * BL, "R8 read spacing", mx - mn, 3 * BL);
        for (int i = 0; i < 3; i++)
            chk(g_order[i + 1] == (g_order[i] + 1) % 4, "R11 rotating grant", g_order[i + 1], (g_order[i] + 1) % 4);

        // hit beats miss
        fork
            req(0, 0, 10, 30, 1'b0, l0);
            req(1, 2, 5, 31, 1'b0, l1);
        join
        repeat (8) @(posedge clk);
        chk(l1 == 0, "R6 hit served first", l1, 0);
        chk(l0 == 1 + TRP + TRCD, "R6 miss after hit", l0, 1 + TRP + TRCD);

        // pending hit protects its bank from precharge
        fork
            req(0, 1, 4, 40, 1'b0, l0);
            req(2, 0, 10, 41, 1'b0, l2);
            req(3, 0, 11, 42, 1'b0, l3);
        join
        repeat (8) @(posedge clk);
        chk(pre_c[0] > g_cyc[2], "R6 no precharge under hit", pre_c[0], g_cyc[2] + 1);

        // read/write turnaround
        fork
            req(0, 1, 4, 50, 1'b0, l0);
            req(1, 3, 6, 51, 1'b1, l1);
        join
        repeat (8) @(posedge clk);
        if (g_cyc[0] < g_cyc[1])
            chk(g_cyc[1] - g_cyc[0] == 2 + BL, "R10 write after read", g_cyc[1] - g_cyc[0], 2 + BL);
        else
            chk(g_cyc[0] - g_cyc[1] == BL, "R10 read after write", g_cyc[0] - g_cyc[1], BL);

        // reset mid-run forgets open rows
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(cmd == CMD_NOP && rdata_beat == 1'b0, "R1 reset again", int'(cmd), 0);
        rst_n = 1'b1;
        req(0, 1, 4, 60, 1'b0, l0);
        chk(l0 == 4, "R1 row unknown after reset", l0, 4);
        repeat (8) @(posedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule